// File: doc/BRIEF.md
# Two-Wire Bus Slave for a 12-Bit Converter

This block is the serial front end of a 12-bit converter. It watches the clock and data lines of an I2C-style two-wire bus, resynchronises both to the system clock, and finds START, repeated START and STOP conditions. It compares the incoming 7-bit device address one bit at a time. At the first bit that differs it stops listening to the bus clock, and it stays that way until the next START. It also stops listening after a STOP. A STOP that arrives during the same clock-high period as its START is treated as malformed and ignored. The all-zero general call address is never acknowledged.

In a write frame every received byte is acknowledged. The byte is then handed to the register logic on `rx_byte` with a one-cycle `rx_valid` strobe. `rx_start` marks a write frame that has just opened. `rx_stop` marks a write frame closed by a STOP or by a repeated START. In a read frame the block sends two bytes taken from `rd_word`. The first carries two zero bits, then the two power-state bits, then data bits 11..8. The block sends the second byte (data bits 7..0) only if the master acknowledges the first. The block drives SDA only through an open-drain pull-down enable.

The FSM states are IDLE (deaf to SCL), ADDR (receiving the address and R/W bit), ADDR_ACK (acknowledging the address), WR_BYTE and WR_ACK (receiving and acknowledging write bytes), and RD_BYTE and RD_ACK (sending a byte and sampling the master's acknowledge). The transitions are:
- START: any state to ADDR.
- Legal STOP: any state to IDLE.
- Address mismatch: ADDR to IDLE.
- Eighth address clock: ADDR to ADDR_ACK.
- End of the address acknowledge: ADDR_ACK to WR_BYTE when R/W=0, or to RD_BYTE when R/W=1.
- Eighth data clock: WR_BYTE to WR_ACK.
- End of a write acknowledge: WR_ACK to WR_BYTE.
- Eighth bit sent: RD_BYTE to RD_ACK.
- Master acknowledge after the first read byte: RD_ACK to RD_BYTE.
- Master not-acknowledge, or the end of the second read byte: RD_ACK to IDLE.

Top module: `two_wire_slave`

## Requirements
- R1: After reset the block is in IDLE, `sda_oe` is 0, and none of `rx_valid`, `rx_start` or `rx_stop` pulses.
- R2: The own address is {ADDR_HI, addr_sel}, sent MSB first after START. The eighth bit is R/W (0 = write, 1 = read). A matching address is acknowledged by `sda_oe`=1 during the ninth SCL clock.
- R3: At the first address bit that differs, the block goes deaf. It gives no acknowledge and no strobes, and SDA stays released, until a new START.
- R4: The general call address (seven zero bits) is never acknowledged, even when the own address is zero.
- R5: A legal STOP returns the block to IDLE, where it ignores SCL until the next START. If a write frame is open, `rx_stop` pulses.
- R6: A STOP in the same SCL high period as the preceding START is ignored, and address reception continues.
- R7: In a write frame, `rx_start` pulses when the address acknowledge ends. Each byte is acknowledged on the ninth clock. The byte appears on `rx_byte` with a one-cycle `rx_valid` pulse after the SCL falling edge that ends its acknowledge.
- R8: A byte cut short by a STOP or START before its acknowledge is not delivered.
- R9: In a read frame the block sends {2'b00, rd_word[13:8]} MSB first. It then sends rd_word[7:0] if the master acknowledged (SDA low on the ninth clock). Here rd_word[13:12] are the power-state bits and rd_word[11:0] are the data bits.
- R10: If the master does not acknowledge a sent byte, the block releases SDA and stays in IDLE until the next START.
- R11: A repeated START begins a new address phase. It closes an open write frame with `rx_stop`. Back-to-back writes separated by a repeated START are each delivered.
- R12: `sda_oe` rises only after an SCL falling edge. It falls only after an SCL falling edge or a bus condition, never in the middle of an SCL high period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_oe | output | 1 | 1 pulls the data line low (open drain) |
| addr_sel | input | 1 | Sets the least significant address bit |
| rd_word | input | DATA_W+2 | Readback: {power state[1:0], data[11:0]} |
| rx_byte | output | 8 | Last byte written by the master |
| rx_valid | output | 1 | One-cycle strobe: rx_byte is new |
| rx_start | output | 1 | One-cycle strobe: write frame opened |
| rx_stop | output | 1 | One-cycle strobe: write frame closed |

## Verification
The bench builds the block with ADDR_HI all zeros and two synchroniser stages. With that setting the own address is either 0 (when addr_sel is low) or 1. This choice brings the general-call rejection within reach of an exhaustive sweep: all 128 addresses are sent with both addr_sel values, and the expected acknowledge is computed arithmetically. Every rejected address is followed by a byte that would match if the block were still listening, which shows that it has gone deaf. Directed frames cover write bursts, repeated STARTs, aborted bytes, the early STOP, deafness after a STOP, and reads of several readback words with and without the master acknowledge.

// File: rtl/tws_pkg.sv
package tws_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WR_BYTE,
        ST_WR_ACK,
        ST_RD_BYTE,
        ST_RD_ACK
    } tws_state_e;
endpackage

// File: rtl/tws_sync.sv
module tws_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain[g] <= 1'b1;
                else if (g == 0) chain[g] <= d;
                else chain[g] <= chain[(g == 0) ? 0 : g-1];
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/tws_bus_cond.sv
module tws_bus_cond #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_evt,
    output logic stop_evt
);
    logic scl_q, sda_q, start_hi;
    logic stop_raw;

    tws_sync #(.STAGES(SYNC_STAGES)) i_sync_scl (.clk(clk), .rst_n(rst_n), .d(scl_i), .q(scl_s));
    tws_sync #(.STAGES(SYNC_STAGES)) i_sync_sda (.clk(clk), .rst_n(rst_n), .d(sda_i), .q(sda_s));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q    <= 1'b1;
            sda_q    <= 1'b1;
            start_hi <= 1'b0;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
            // Remember that the current SCL high period began a frame
            if (start_evt)     start_hi <= 1'b1;
            else if (scl_fall) start_hi <= 1'b0;
        end
    end

    assign scl_rise  = scl_s & ~scl_q;
    assign scl_fall  = ~scl_s & scl_q;
    assign start_evt = scl_s & scl_q & sda_q & ~sda_s;
    assign stop_raw  = scl_s & scl_q & ~sda_q & sda_s;
    // A STOP in the same high period as its START is malformed
    assign stop_evt  = stop_raw & ~start_hi;
endmodule

// File: rtl/two_wire_slave.sv
module two_wire_slave
    import tws_pkg::*;
#(
    parameter logic [5:0] ADDR_HI     = 6'b001000,
    parameter int         SYNC_STAGES = 2,
    parameter int         DATA_W      = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    input  logic              addr_sel,
    input  logic [DATA_W+1:0] rd_word,
    output logic [7:0]        rx_byte,
    output logic              rx_valid,
    output logic              rx_start,
    output logic              rx_stop
);
    localparam int BYTE_W = 8;
    localparam int CNT_W  = $clog2(BYTE_W + 1);
    localparam int HI_W   = DATA_W + 2 - BYTE_W;
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] CNT_A0   = CNT_W'(BYTE_W - 2);

    logic scl_s, sda_s, scl_rise, scl_fall, start_evt, stop_evt;
    tws_state_e state_q, state_d;
    logic [CNT_W-1:0]  cnt_q;
    logic [BYTE_W-1:0] sh_q;
    logic rw_q, mack_q, second_q, wr_open_q;
    logic [6:0] own_addr;
    logic [7:0] own_byte;
    logic exp_bit, bit_ok;
    logic [7:0] rd_first;

    tws_bus_cond #(.SYNC_STAGES(SYNC_STAGES)) i_cond (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_evt(start_evt), .stop_evt(stop_evt)
    );

    assign own_addr = {ADDR_HI, addr_sel};
    assign own_byte = {own_addr, 1'b0};
    assign exp_bit  = own_byte[3'd7 - cnt_q[2:0]];
    // Bit-by-bit compare; an all-zero address (general call) fails at A0
    assign bit_ok   = (sda_s == exp_bit) && !((cnt_q == CNT_A0) && (own_addr == 7'd0));
    assign rd_first = {{(BYTE_W-HI_W){1'b0}}, rd_word[DATA_W+1:BYTE_W]};

    always_comb begin
        state_d = state_q;
        if (start_evt) state_d = ST_ADDR;
        else if (stop_evt) state_d = ST_IDLE;
        else begin
            unique case (state_q)
                ST_IDLE:     state_d = ST_IDLE;
                ST_ADDR: begin
                    if (scl_rise && (cnt_q < CNT_FULL - 1'b1) && !bit_ok) state_d = ST_IDLE;
                    else if (scl_fall && cnt_q == CNT_FULL)               state_d = ST_ADDR_ACK;
                end
                ST_ADDR_ACK: if (scl_fall) state_d = rw_q ? ST_RD_BYTE : ST_WR_BYTE;
                ST_WR_BYTE:  if (scl_fall && cnt_q == CNT_FULL) state_d = ST_WR_ACK;
                ST_WR_ACK:   if (scl_fall) state_d = ST_WR_BYTE;
                ST_RD_BYTE:  if (scl_fall && cnt_q == CNT_FULL) state_d = ST_RD_ACK;
                ST_RD_ACK:   if (scl_fall) state_d = (mack_q && !second_q) ? ST_RD_BYTE : ST_IDLE;
                default:     state_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            sh_q      <= '0;
            rw_q      <= 1'b0;
            mack_q    <= 1'b0;
            second_q  <= 1'b0;
            wr_open_q <= 1'b0;
            sda_oe    <= 1'b0;
            rx_byte   <= '0;
            rx_valid  <= 1'b0;
            rx_start  <= 1'b0;
            rx_stop   <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            rx_start <= 1'b0;
            rx_stop  <= 1'b0;
            if (start_evt || stop_evt) begin
                cnt_q     <= '0;
                sda_oe    <= 1'b0;
                rx_stop   <= wr_open_q;
                wr_open_q <= 1'b0;
            end else begin
                unique case (state_q)
                    ST_ADDR, ST_WR_BYTE: begin
                        if (scl_rise) begin
                            sh_q  <= {sh_q[BYTE_W-2:0], sda_s};
                            cnt_q <= cnt_q + 1'b1;
                        end else if (scl_fall && cnt_q == CNT_FULL) begin
                            sda_oe <= 1'b1;
                            if (state_q == ST_ADDR) rw_q <= sh_q[0];
                        end
                    end
                    ST_ADDR_ACK: if (scl_fall) begin
                        cnt_q <= '0;
                        if (rw_q) begin
                            sh_q     <= rd_first;
                            sda_oe   <= ~rd_first[BYTE_W-1];
                            second_q <= 1'b0;
                        end else begin
                            sda_oe    <= 1'b0;
                            rx_start  <= 1'b1;
                            wr_open_q <= 1'b1;
                        end
                    end
                    ST_WR_ACK: if (scl_fall) begin
                        sda_oe   <= 1'b0;
                        cnt_q    <= '0;
                        rx_byte  <= sh_q;
                        rx_valid <= 1'b1;
                    end
                    ST_RD_BYTE: begin
                        if (scl_rise) cnt_q <= cnt_q + 1'b1;
                        else if (scl_fall) begin
                            if (cnt_q == CNT_FULL) sda_oe <= 1'b0;
                            else begin
                                sh_q   <= {sh_q[BYTE_W-2:0], 1'b0};
                                sda_oe <= ~sh_q[BYTE_W-2];
                            end
                        end
                    end
                    ST_RD_ACK: begin
                        if (scl_rise) mack_q <= ~sda_s;
                        else if (scl_fall && mack_q && !second_q) begin
                            sh_q     <= rd_word[BYTE_W-1:0];
                            sda_oe   <= ~rd_word[BYTE_W-1];
                            cnt_q    <= '0;
                            second_q <= 1'b1;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/two_wire_slave_chk.sv
module two_wire_slave_chk
    import tws_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input tws_state_e state_q,
    input logic       sda_oe,
    input logic       scl_s,
    input logic       scl_fall,
    input logic       start_evt,
    input logic       stop_evt,
    input logic       rx_valid,
    input logic       rx_start,
    input logic       rx_stop
);
    AST_OE_RISE_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> $past(scl_fall)); // R12
    AST_OE_DROP_AFTER_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sda_oe) |-> $past(scl_fall || start_evt || stop_evt)); // R12
    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> !sda_oe); // R3
    AST_STOP_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        stop_evt |=> (state_q == ST_IDLE)); // R5
    AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rx_valid, rx_start, rx_stop})); // R7
    AST_BYTE_WHILE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> !scl_s); // R7
endmodule

bind two_wire_slave two_wire_slave_chk i_chk (
    .clk(clk), .rst_n(rst_n), .state_q(state_q), .sda_oe(sda_oe), .scl_s(scl_s),
    .scl_fall(scl_fall), .start_evt(start_evt), .stop_evt(stop_evt),
    .rx_valid(rx_valid), .rx_start(rx_start), .rx_stop(rx_stop)
);

// File: tb/test_two_wire_slave.sv
`timescale 1ns/1ps
module test_two_wire_slave;
    localparam int T = 6;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1, sda_m = 1'b1, addr_sel = 1'b1;
    logic [13:0] rd_word = '0;
    logic sda_oe, rx_valid, rx_start, rx_stop;
    logic [7:0] rx_byte;
    wire sda_line = sda_m & ~sda_oe;

    int n_chk = 0, n_fail = 0;
    int n_valid = 0, n_start = 0, n_stop = 0;
    logic [7:0] last_byte = '0;
    int scl_hi = 0, oe_viol = 0;
    logic oe_prev = 1'b0;
    bit done = 0;

    always #5 clk = ~clk;

    two_wire_slave #(.ADDR_HI(6'd0), .SYNC_STAGES(2), .DATA_W(12)) i_two_wire_slave (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_oe(sda_oe),
        .addr_sel(addr_sel), .rd_word(rd_word), .rx_byte(rx_byte),
        .rx_valid(rx_valid), .rx_start(rx_start), .rx_stop(rx_stop)
    );

    always @(negedge clk) begin
        if (rx_valid) begin n_valid++; last_byte = rx_byte; end
        if (rx_start) n_start++;
        if (rx_stop)  n_stop++;
        if (sda_oe != oe_prev && scl_hi > 3) oe_viol++;
        oe_prev = sda_oe;
        scl_hi = scl ? scl_hi + 1 : 0;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wt;
        repeat (T) @(negedge clk);
    endtask

    task automatic bus_start; // from idle or with SCL low (repeated START)
        sda_m = 1'b1; wt; scl = 1'b1; wt; sda_m = 1'b0; wt; scl = 1'b0; wt;
    endtask

    task automatic bus_stop; // entered with SCL low
        sda_m = 1'b0; wt; scl = 1'b1; wt; sda_m = 1'b1; wt;
    endtask

    task automatic clk_bit(input logic b, output logic r);
        sda_m = b; wt; scl = 1'b1; wt; r = sda_line; scl = 1'b0; wt;
    endtask

    task automatic wr_byte(input logic [7:0] b, output logic ack);
        logic r;
        for (int i = 7; i >= 0; i--) clk_bit(b[i], r);
        clk_bit(1'b1, r);
        ack = ~r;
    endtask

    task automatic rd_byte(input logic give_ack, output logic [7:0] b);
        logic r;
        for (int i = 7; i >= 0; i--) begin clk_bit(1'b1, r); b[i] = r; end
        clk_bit(~give_ack, r);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic ack;
        logic [7:0] b0, b1;
        int sv, vv, st, sp;
        logic [13:0] words [4];
        words[0] = 14'h3FFF; words[1] = 14'h0000; words[2] = 14'h2A5C; words[3] = 14'h1234;

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        // R1: reset state
        check("R1 sda_oe after reset", sda_oe, 0);
        check("R1 strobes after reset", {rx_valid, rx_start, rx_stop}, 0);
        check("R1 no strobe counts", n_valid + n_start + n_stop, 0);

        // R2 R3 R4: exhaustive address sweep; own address = addr_sel (ADDR_HI = 0)
        for (int s = 0; s < 2; s++) begin
            addr_sel = s[0];
            for (int a = 0; a < 128; a++) begin
                logic exp_ack;
                exp_ack = (a == s) && (a != 0);
                st = n_start;
                bus_start;
                wr_byte({a[6:0], 1'b0}, ack);
                if (a == 0) check("R4 general call not acknowledged", ack, 0);
                else        check("R2 address acknowledge", ack, exp_ack);
                if (!exp_ack) begin
                    wr_byte(8'h02, ack);
                    check("R3 deaf after mismatch", ack, 0);
                    check("R3 no strobe while deaf", n_start, st);
                end
                bus_stop;
            end
        end
        addr_sel = 1'b1;

        // R7: write burst
        vv = n_valid; st = n_start; sp = n_stop;
        bus_start;
        wr_byte(8'h02, ack);
        check("R2 write address ack", ack, 1);
        wr_byte(8'h5A, ack);
        check("R7 data byte ack", ack, 1);
        check("R7 first byte value", last_byte, 8'h5A);
        wr_byte(8'hA5, ack);
        check("R7 second byte value", last_byte, 8'hA5);
        check("R7 byte count", n_valid - vv, 2);
        check("R7 rx_start count", n_start - st, 1);
        bus_stop;
        check("R5 rx_stop on STOP", n_stop - sp, 1);

        // R5: deaf after STOP
        scl = 1'b0; wt;
        wr_byte(8'h02, ack);
        check("R5 no ack after STOP without START", ack, 0);
        bus_stop;

        // R11: back-to-back writes with repeated START
        vv = n_valid; sp = n_stop;
        bus_start;
        wr_byte(8'h02, ack); wr_byte(8'h11, ack);
        bus_start;
        check("R11 rx_stop at repeated START", n_stop - sp, 1);
        wr_byte(8'h02, ack);
        check("R11 address ack after repeated START", ack, 1);
        wr_byte(8'h22, ack);
        bus_stop;
        check("R11 both bytes delivered", n_valid - vv, 2);
        check("R11 last byte", last_byte, 8'h22);

        // R8: byte aborted by STOP
        vv = n_valid; sp = n_stop;
        bus_start;
        wr_byte(8'h02, ack);
        for (int i = 0; i < 4; i++) begin logic r; clk_bit(1'b1, r); end
        bus_stop;
        check("R8 aborted byte not delivered", n_valid - vv, 0);
        check("R8 frame closed", n_stop - sp, 1);

        // R6: STOP in the same SCL high period as START is ignored
        sda_m = 1'b0; wt; sda_m = 1'b1; wt; scl = 1'b0; wt;
        wr_byte(8'h02, ack);
        check("R6 early STOP ignored, address acked", ack, 1);
        bus_stop;

        // R9: read sequences
        foreach (words[k]) begin
            rd_word = words[k];
            bus_start;
            wr_byte(8'h02, ack); wr_byte(8'hC0, ack);
            bus_start;
            wr_byte(8'h03, ack);
            check("R9 read address ack", ack, 1);
            rd_byte(1'b1, b0);
            rd_byte(1'b0, b1);
            bus_stop;
            check("R9 first read byte", b0, {2'b00, words[k][13:8]});
            check("R9 second read byte", b1, words[k][7:0]);
        end

        // R10: master NACK after first byte releases the bus
        rd_word = 14'h0F0F;
        bus_start;
        wr_byte(8'h03, ack);
        rd_byte(1'b0, b0);
        check("R10 first byte before NACK", b0, 8'h0F);
        rd_byte(1'b1, b1);
        check("R10 SDA released after NACK", b1, 8'hFF);
        bus_stop;

        // R12: SDA never changed during a stable SCL high period
        check("R12 sda_oe changes during SCL high", oe_viol, 0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule